// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers single-cycle event pulses from a storage host controller into a local sticky status register. A local enable register of the same layout selects which pending bits contribute to a one-bit local summary. That summary, together with the interrupt from a sibling controller, feeds a two-bit global status register. Access to the global register is shared by both controllers.

Each global bit is captured only while its status-enable bit is set. The single interrupt output is driven from the global status bits that have their signal-enable bit set. Software reaches all five registers over a plain single-cycle register bus. Status bits at both levels are cleared by writing ones.

Register word addresses are 0 local status, 1 local enable, 2 global status, 3 global status-enable and 4 global signal-enable. Reads return data combinationally from `addr_i`. Writes take effect at the clock edge on which `we_i` is high.

Top module: `irq_tl_ctrl`

## Requirements
- R1: After reset, all five registers read 0 and `irq_o` is low.
- R2: An event pulse on `evt_i` sets the matching local status bit whether or not that bit is enabled. The valid positions are 0 card detect, 1 status change, 2 memory mode, 3 I/O mode, 8 true IDE mode, 9 PIO transfer error, 10 buffer available and 11 transfer done. Bits 4 to 7 are reserved: they never set and they read 0.
- R3: Writing to local status (address 0) clears each bit written as 1. Bits written as 0 are left unchanged.
- R4: If an event and a write-one clear hit the same status bit in the same cycle, the bit stays set.
- R5: The local enable register (address 1) reads back what was written, masked to the valid positions. The local summary is the OR of status AND enable.
- R6: Global status bit 0 latches the local summary, and bit 1 latches `sib_irq_i`. Each bit latches only while its bit in the status-enable register (address 3) is 1.
- R7: Global status (address 2) is write-one-to-clear. If its source is still active during the clear, the bit stays set.
- R8: `irq_o` is the OR of global status AND signal-enable (address 4). Signal-enable has no effect on latching.
- R9: With every enable set, an event applied before clock edge k raises `irq_o` after edge k+1 and not earlier.
- R10: Writes to addresses 5 to 7 change no register, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 12 | Write data |
| rdata_o | output | 12 | Read data for `addr_i` |
| evt_i | input | 12 | Event pulses, one per local status bit |
| sib_irq_i | input | 1 | Interrupt from the sibling controller |
| irq_o | output | 1 | Interrupt line |

## Verification
A local status bit that is lost or stuck shows up on the next read of address 0. Because of the two-stage path, the same fault also shows up on `irq_o` two edges after the event.

A wrong gate between the levels, such as latching while status-enable is off or using signal-enable for latching, shows up as a global status read that differs within one edge of the enable write. The tests set up the event-versus-clear collisions at both levels in the exact cycle of the clear. This exposes a reversed priority in the first read after the collision.

// File: rtl/irq_tl_pkg.sv
package irq_tl_pkg;
  localparam int LOC_W = 12;
  localparam int GLB_W = 2;
  localparam int ADDR_W = 3;
  // valid local positions: 0..3 and 8..11
  localparam logic [LOC_W-1:0] LOC_VALID = 12'hF0F;
  localparam logic [GLB_W-1:0] GLB_VALID = 2'b11;

  typedef enum logic [ADDR_W-1:0] {
    A_LSTAT = 3'd0,
    A_LEN   = 3'd1,
    A_GSTAT = 3'd2,
    A_GSEN  = 3'd3,
    A_GSIG  = 3'd4
  } reg_addr_e;

  localparam int G_LOCAL = 0;
  localparam int G_SIB   = 1;
endpackage

// File: rtl/irq_tl_w1c.sv
module irq_tl_w1c #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((q_q & ~clr_i) | set_i) & MASK;  // set wins
  end

  assign q_o = q_q;

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & MASK) != '0) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK)));
  // R3
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
  // R2
  masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~MASK) == '0);
endmodule

// File: rtl/irq_tl_rw.sv
module irq_tl_rw #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= d_i & MASK;
  end

  assign q_o = q_q;

  // R5
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/irq_tl_ctrl.sv
module irq_tl_ctrl
  import irq_tl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOC_W-1:0]  wdata_i,
  output logic [LOC_W-1:0]  rdata_o,
  input  logic [LOC_W-1:0]  evt_i,
  input  logic              sib_irq_i,
  output logic              irq_o
);
  logic [LOC_W-1:0] lstat_q, len_q, lclr;
  logic [GLB_W-1:0] gstat_q, gsen_q, gsig_q, gsrc, gset, gclr;
  logic             loc_sum;
  logic             wr_lstat, wr_len, wr_gstat, wr_gsen, wr_gsig;

  assign wr_lstat = we_i && (addr_i == A_LSTAT);
  assign wr_len   = we_i && (addr_i == A_LEN);
  assign wr_gstat = we_i && (addr_i == A_GSTAT);
  assign wr_gsen  = we_i && (addr_i == A_GSEN);
  assign wr_gsig  = we_i && (addr_i == A_GSIG);

  assign lclr = wr_lstat ? wdata_i : '0;
  assign gclr = wr_gstat ? wdata_i[GLB_W-1:0] : '0;

  irq_tl_w1c #(.W(LOC_W), .MASK(LOC_VALID)) u_lstat (
    .clk_i, .rst_ni, .set_i(evt_i), .clr_i(lclr), .q_o(lstat_q));

  irq_tl_rw #(.W(LOC_W), .MASK(LOC_VALID)) u_len (
    .clk_i, .rst_ni, .we_i(wr_len), .d_i(wdata_i), .q_o(len_q));

  assign loc_sum = |(lstat_q & len_q);

  assign gsrc[G_LOCAL] = loc_sum;
  assign gsrc[G_SIB]   = sib_irq_i;

  for (genvar g = 0; g < GLB_W; g++) begin : g_gate
    assign gset[g] = gsrc[g] & gsen_q[g];
  end

  irq_tl_w1c #(.W(GLB_W), .MASK(GLB_VALID)) u_gstat (
    .clk_i, .rst_ni, .set_i(gset), .clr_i(gclr), .q_o(gstat_q));

  irq_tl_rw #(.W(GLB_W), .MASK(GLB_VALID)) u_gsen (
    .clk_i, .rst_ni, .we_i(wr_gsen), .d_i(wdata_i[GLB_W-1:0]), .q_o(gsen_q));

  irq_tl_rw #(.W(GLB_W), .MASK(GLB_VALID)) u_gsig (
    .clk_i, .rst_ni, .we_i(wr_gsig), .d_i(wdata_i[GLB_W-1:0]), .q_o(gsig_q));

  assign irq_o = |(gstat_q & gsig_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LSTAT: rdata_o = lstat_q;
      A_LEN:   rdata_o = len_q;
      A_GSTAT: rdata_o[GLB_W-1:0] = gstat_q;
      A_GSEN:  rdata_o[GLB_W-1:0] = gsen_q;
      A_GSIG:  rdata_o[GLB_W-1:0] = gsig_q;
      default: rdata_o = '0;
    endcase
  end

  // R6
  glb_local_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gstat_q[G_LOCAL]) |-> $past(gsen_q[G_LOCAL] && loc_sum));
  // R6
  glb_sib_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gstat_q[G_SIB]) |-> $past(gsen_q[G_SIB] && sib_irq_i));
  // R8
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(we_i));
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(gsig_q != '0) || $past(we_i)));
endmodule

// File: tb/irq_tl_ctrl_test.sv
module irq_tl_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic [11:0] rdata;
  logic [11:0] evt = '0;
  logic        sib = 1'b0;
  logic        irq;

  int err_cnt = 0;
  int chk_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tl_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .sib_irq_i(sib), .irq_o(irq));

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    chk_cnt++;
    if (got !== exp) begin
      err_cnt++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [11:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [11:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    sib = 1'b0;
    wr(3'd3, 12'h0);
    wr(3'd4, 12'h0);
    wr(3'd1, 12'h0);
    wr(3'd0, 12'hFFF);
    wr(3'd2, 12'h3);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 5; a++) rd_chk("R1 reset reg", 3'(a), 12'h0);
    check("R1 reset irq", {11'b0, irq}, 12'h0);
  endtask

  task automatic t_local_set();
    clear_all();
    pulse(12'hFFF);
    rd_chk("R2 event set, reserved clear", 3'd0, 12'hF0F);
    step();
    check("R2 no irq when disabled", {11'b0, irq}, 12'h0);
  endtask

  task automatic t_w1c();
    wr(3'd0, 12'h001);
    rd_chk("R3 clear bit0", 3'd0, 12'hF0E);
    wr(3'd0, 12'h000);
    rd_chk("R3 zero write keeps", 3'd0, 12'hF0E);
    wr(3'd0, 12'hFFF);
    rd_chk("R3 clear all", 3'd0, 12'h000);
  endtask

  task automatic t_race();
    clear_all();
    pulse(12'h200);
    @(negedge clk);
    evt = 12'h200; we = 1'b1; addr = 3'd0; wdata = 12'h200;
    @(negedge clk);
    evt = '0; we = 1'b0; wdata = '0;
    rd_chk("R4 event wins over clear", 3'd0, 12'h200);
  endtask

  task automatic t_enable();
    clear_all();
    wr(3'd1, 12'hFFF);
    rd_chk("R5 enable readback masked", 3'd1, 12'hF0F);
    wr(3'd3, 12'h1);
    wr(3'd4, 12'h1);
    pulse(12'h008);
    step();
    check("R5 summary reaches irq", {11'b0, irq}, 12'h1);
  endtask

  task automatic t_global_gate();
    clear_all();
    wr(3'd1, 12'h400);
    pulse(12'h400);
    wr(3'd4, 12'h3);
    step();
    rd_chk("R6 no latch without status-enable", 3'd2, 12'h0);
    check("R6 irq low without latch", {11'b0, irq}, 12'h0);
    wr(3'd3, 12'h1);
    step();
    rd_chk("R6 latch after status-enable", 3'd2, 12'h1);
    check("R8 irq high", {11'b0, irq}, 12'h1);
  endtask

  task automatic t_sibling();
    clear_all();
    sib = 1'b1;
    step(); step();
    rd_chk("R6 sibling gated", 3'd2, 12'h0);
    wr(3'd3, 12'h2);
    step();
    sib = 1'b0;
    step();
    rd_chk("R6 sibling latched and held", 3'd2, 12'h2);
    check("R8 latch independent of signal-enable", {11'b0, irq}, 12'h0);
    wr(3'd4, 12'h2);
    check("R8 signal-enable drives irq", {11'b0, irq}, 12'h1);
  endtask

  task automatic t_global_w1c();
    clear_all();
    wr(3'd1, 12'h001);
    wr(3'd3, 12'h1);
    pulse(12'h001);
    step();
    rd_chk("R7 global set", 3'd2, 12'h1);
    wr(3'd2, 12'h1);
    rd_chk("R7 relatch while source active", 3'd2, 12'h1);
    wr(3'd0, 12'h001);
    wr(3'd2, 12'h1);
    rd_chk("R7 clear after source gone", 3'd2, 12'h0);
  endtask

  task automatic t_signal();
    clear_all();
    wr(3'd1, 12'h001);
    wr(3'd3, 12'h3);
    pulse(12'h001);
    sib = 1'b1;
    step(); step();
    sib = 1'b0;
    rd_chk("R8 both global set", 3'd2, 12'h3);
    check("R8 irq off with signal-enable 0", {11'b0, irq}, 12'h0);
    wr(3'd4, 12'h1);
    check("R8 irq on bit0", {11'b0, irq}, 12'h1);
    wr(3'd0, 12'h001);
    wr(3'd2, 12'h1);
    check("R8 bit1 pending but masked", {11'b0, irq}, 12'h0);
  endtask

  task automatic t_latency();
    clear_all();
    wr(3'd1, 12'h800);
    wr(3'd3, 12'h1);
    wr(3'd4, 12'h1);
    pulse(12'h800);
    check("R9 irq low after first edge", {11'b0, irq}, 12'h0);
    step();
    check("R9 irq high after second edge", {11'b0, irq}, 12'h1);
  endtask

  task automatic t_unused_addr();
    clear_all();
    wr(3'd1, 12'h00F);
    wr(3'd7, 12'hFFF);
    wr(3'd5, 12'hFFF);
    rd_chk("R10 enable untouched", 3'd1, 12'h00F);
    rd_chk("R10 status untouched", 3'd0, 12'h000);
    rd_chk("R10 gsen untouched", 3'd3, 12'h000);
    rd_chk("R10 unused reads 0", 3'd7, 12'h000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_local_set();
    t_w1c();
    t_race();
    t_enable();
    t_global_gate();
    t_sibling();
    t_global_w1c();
    t_signal();
    t_latency();
    t_unused_addr();
    $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt);
    $finish;
  end
endmodule